// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a combinational clamping datapath for 32-bit integer operands with one registered sticky saturation flag. An opcode selects one of: signed or unsigned saturating add and subtract, a doubling operation that saturates, a plain wrapping add that still reports signed overflow, and saturation of a value to a selectable bit position. The bit-position operations come as a whole-word form and as a dual 16-bit lane form.

The result follows the inputs in the same cycle. When an operation is presented with `valid_i` high and its result had to be clamped, the sticky flag `q_o` goes high on the next clock edge. It stays high until software-side logic pulses `clr_q_i`. A datapath or execution stage can place the unit next to its adder and accumulate overflow across a sequence of operations.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 1 (signed add): if both operands have the same sign and the sum's sign differs, the result is 0x7FFFFFFF for a non-negative first operand and 0x80000000 for a negative one. Otherwise the result is the sum.
- R2: Opcode 2 (signed subtract a-b): if the operand signs differ and the difference's sign differs from a, the result clamps as in R1. Otherwise the result is the difference.
- R3: Opcode 3 (unsigned add): a sum that carries out of 32 bits gives 0xFFFFFFFF. Otherwise the result is the sum.
- R4: Opcode 4 (unsigned subtract a-b): the result is 0 when b > a, and a-b otherwise.
- R5: Opcode 5 (doubling, operand a): a signed input >= 0x40000000 gives 0x7FFFFFFF, and a signed input <= 0xC0000000 gives 0x80000000; both count as clamps. Any other input gives a<<1.
- R6: Opcode 6 (signed saturate to position s=pos_i): let t = a>>>s. If t > 0 the result is 2^s-1; if t < -1 the result is ~(2^s-1). Otherwise a passes through.
- R7: Opcode 7 (unsigned saturate to s=pos_i): a negative a gives 0, and a > 2^s-1 gives 2^s-1. Otherwise a passes through.
- R8: Opcodes 8 (signed) and 9 (unsigned) treat a[15:0] and a[31:16] as sign-extended lanes. Each lane is saturated independently as in R6/R7 with the same s, and bits [15:0] of each lane result return to the lane's position. A clamp in either lane counts.
- R9: Opcode 0 (add with flag): the result is the wrapped 32-bit sum, and signed overflow as defined in R1 counts as a clamp.
- R10: q_o goes high on the clock edge that samples valid_i=1 with a clamping result. A non-clamping operation, or a clamping one with valid_i=0, leaves q_o unchanged.
- R11: clr_q_i=1 clears q_o on the next edge, unless a valid clamping operation arrives in the same cycle, in which case q_o is 1.
- R12: After rst_ni is asserted q_o is 0. Opcodes 10 to 15 give result 0 and never count as a clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe; qualifies flag update |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand / value to saturate |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Saturation bit position s |
| clr_q_i | input | 1 | Synchronous clear of the sticky flag |
| res_o | output | 32 | Result |
| q_o | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach from the ports is the dual-lane form, where one lane clamps high while the other clamps low, or where one lane clamps and the other passes through. A fault that merges or swaps lanes is only visible when the two lanes disagree. The stimulus table therefore packs opposite-sign values into the two halves at small bit positions. The doubling edge 0xC0000000 is another hard case: it is exactly representable when doubled, yet it must still raise the flag, so it is driven on its own with the flag cleared just before. The collision of clear and clamp in one cycle is also driven directly.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_ADDQ   = 4'd0,
    OP_SADD   = 4'd1,
    OP_SSUB   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_DBL    = 4'd5,
    OP_SSAT   = 4'd6,
    OP_USAT   = 4'd7,
    OP_SSAT16 = 4'd8,
    OP_USAT16 = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_word_ops.sv
module sat_word_ops
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sat_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         clamp_o
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] P_QTR = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] N_QTR = {2'b11, {(W-2){1'b0}}};

  logic [W:0]   sum_x;
  logic [W-1:0] diff;
  logic [W-1:0] sig_clamp;
  logic s_add_ov, s_sub_ov, u_add_ov, u_sub_ov, dbl_hi, dbl_lo;

  assign sum_x     = {1'b0, a_i} + {1'b0, b_i};
  assign diff      = a_i - b_i;
  assign s_add_ov  = (a_i[W-1] == b_i[W-1]) && (sum_x[W-1] != a_i[W-1]);
  assign s_sub_ov  = (a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]);
  assign u_add_ov  = sum_x[W];
  assign u_sub_ov  = b_i > a_i;
  assign sig_clamp = a_i[W-1] ? S_MIN : S_MAX;
  assign dbl_hi    = $signed(a_i) >= $signed(P_QTR);
  assign dbl_lo    = $signed(a_i) <= $signed(N_QTR);

  always_comb begin
    res_o   = '0;
    clamp_o = 1'b0;
    unique case (op_i)
      OP_ADDQ: begin res_o = sum_x[W-1:0]; clamp_o = s_add_ov; end
      OP_SADD: begin res_o = s_add_ov ? sig_clamp : sum_x[W-1:0]; clamp_o = s_add_ov; end
      OP_SSUB: begin res_o = s_sub_ov ? sig_clamp : diff; clamp_o = s_sub_ov; end
      OP_UADD: begin res_o = u_add_ov ? '1 : sum_x[W-1:0]; clamp_o = u_add_ov; end
      OP_USUB: begin res_o = u_sub_ov ? '0 : diff; clamp_o = u_sub_ov; end
      OP_DBL: begin
        if (dbl_hi)      res_o = S_MAX;
        else if (dbl_lo) res_o = S_MIN;
        else             res_o = {a_i[W-2:0], 1'b0};
        clamp_o = dbl_hi || dbl_lo;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [PW-1:0] pos_i,
  input  logic          uns_i,
  output logic [W-1:0]  res_o,
  output logic          clamp_o
);
  logic [W-1:0]        mask;
  logic signed [W-1:0] top;
  logic s_hi, s_lo, u_neg, u_hi;

  assign mask  = (W'(1) << pos_i) - W'(1);
  assign top   = $signed(val_i) >>> pos_i;
  assign s_hi  = !top[W-1] && (|top);
  assign s_lo  = top[W-1] && !(&top);
  assign u_neg = val_i[W-1];
  assign u_hi  = !u_neg && (val_i > mask);

  always_comb begin
    res_o   = val_i;
    clamp_o = 1'b0;
    if (uns_i) begin
      if (u_neg)     begin res_o = '0;   clamp_o = 1'b1; end
      else if (u_hi) begin res_o = mask; clamp_o = 1'b1; end
    end else begin
      if (s_hi)      begin res_o = mask;  clamp_o = 1'b1; end
      else if (s_lo) begin res_o = ~mask; clamp_o = 1'b1; end
    end
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              clr_q_i,
  output logic [DATA_W-1:0] res_o,
  output logic              q_o
);
  localparam int LANE_W = DATA_W / 2;
  localparam int N_LANE = 2;

  sat_op_e op;
  assign op = sat_op_e'(op_i);

  logic [DATA_W-1:0] word_res;
  logic              word_clamp;

  sat_word_ops #(.W(DATA_W)) u_word (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op),
    .res_o  (word_res),
    .clamp_o(word_clamp)
  );

  logic uns_sel;
  assign uns_sel = (op == OP_USAT) || (op == OP_USAT16);

  logic [DATA_W-1:0] full_res;
  logic              full_clamp;

  sat_clamp #(.W(DATA_W), .PW(POS_W)) u_full (
    .val_i  (a_i),
    .pos_i  (pos_i),
    .uns_i  (uns_sel),
    .res_o  (full_res),
    .clamp_o(full_clamp)
  );

  logic [DATA_W-1:0] lane_full [N_LANE];
  logic [N_LANE-1:0] lane_clamp;
  logic [DATA_W-1:0] dual_res;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic [DATA_W-1:0] lane_in;
    assign lane_in = {{LANE_W{a_i[g*LANE_W+LANE_W-1]}}, a_i[g*LANE_W +: LANE_W]};
    sat_clamp #(.W(DATA_W), .PW(POS_W)) u_lane (
      .val_i  (lane_in),
      .pos_i  (pos_i),
      .uns_i  (uns_sel),
      .res_o  (lane_full[g]),
      .clamp_o(lane_clamp[g])
    );
    assign dual_res[g*LANE_W +: LANE_W] = lane_full[g][LANE_W-1:0];
  end

  logic clamp_any;

  always_comb begin
    unique case (op)
      OP_SSAT, OP_USAT: begin res_o = full_res; clamp_any = full_clamp; end
      OP_SSAT16, OP_USAT16: begin res_o = dual_res; clamp_any = |lane_clamp; end
      default: begin res_o = word_res; clamp_any = word_clamp; end
    endcase
  end

  // a fresh clamp outranks a clear in the same cycle
  logic q_r;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    q_r <= 1'b0;
    else if (valid_i && clamp_any)  q_r <= 1'b1;
    else if (clr_q_i)               q_r <= 1'b0;
  end
  assign q_o = q_r;
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [POS_W-1:0]  pos_i,
  input logic              clr_q_i,
  input logic [DATA_W-1:0] res_o,
  input logic              q_o
);
  p_sadd_sign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd1 && a_i[DATA_W-1] == b_i[DATA_W-1]) |-> res_o[DATA_W-1] == a_i[DATA_W-1]);

  p_ssub_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2 && a_i[DATA_W-1] != b_i[DATA_W-1]) |-> res_o[DATA_W-1] == a_i[DATA_W-1]);

  p_uadd_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3) |-> res_o >= a_i);

  p_usub_ceil_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |-> res_o <= a_i);

  p_usat_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |-> (res_o >> pos_i) == '0);

  p_q_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(valid_i));

  p_q_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_q_i) |=> q_o);

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q_i && !valid_i) |=> !q_o);
endmodule

bind sat_arith_unit sat_arith_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .pos_i  (pos_i),
  .clr_q_i(clr_q_i),
  .res_o  (res_o),
  .q_o    (q_o)
);

// File: tb/sim_sat_arith_unit.sv
module sim_sat_arith_unit;
  localparam int CLK_P = 10;
  localparam int N_VEC = 27;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  pos;
    logic [31:0] res;
    logic        q;
  } vec_t;

  localparam vec_t VEC [N_VEC] = '{
    '{4'd1, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1}, // R1
    '{4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1}, // R1
    '{4'd1, 32'h00000005, 32'hFFFFFFFD, 5'd0, 32'h00000002, 1'b0}, // R1
    '{4'd2, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1}, // R2
    '{4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1}, // R2
    '{4'd2, 32'h0000000A, 32'h00000003, 5'd0, 32'h00000007, 1'b0}, // R2
    '{4'd3, 32'hFFFFFFF0, 32'h00000020, 5'd0, 32'hFFFFFFFF, 1'b1}, // R3
    '{4'd3, 32'h00000001, 32'h00000002, 5'd0, 32'h00000003, 1'b0}, // R3
    '{4'd4, 32'h00000003, 32'h00000005, 5'd0, 32'h00000000, 1'b1}, // R4
    '{4'd4, 32'h00000005, 32'h00000005, 5'd0, 32'h00000000, 1'b0}, // R4
    '{4'd5, 32'h40000000, 32'h0,        5'd0, 32'h7FFFFFFF, 1'b1}, // R5
    '{4'd5, 32'h3FFFFFFF, 32'h0,        5'd0, 32'h7FFFFFFE, 1'b0}, // R5
    '{4'd5, 32'hC0000000, 32'h0,        5'd0, 32'h80000000, 1'b1}, // R5
    '{4'd5, 32'hC0000001, 32'h0,        5'd0, 32'h80000002, 1'b0}, // R5
    '{4'd6, 32'h000000C8, 32'h0,        5'd7, 32'h0000007F, 1'b1}, // R6
    '{4'd6, 32'hFFFFFF00, 32'h0,        5'd7, 32'hFFFFFF80, 1'b1}, // R6
    '{4'd6, 32'hFFFFFF80, 32'h0,        5'd7, 32'hFFFFFF80, 1'b0}, // R6
    '{4'd7, 32'h00000100, 32'h0,        5'd8, 32'h000000FF, 1'b1}, // R7
    '{4'd7, 32'h80000000, 32'h0,        5'd8, 32'h00000000, 1'b1}, // R7
    '{4'd7, 32'h000000FF, 32'h0,        5'd8, 32'h000000FF, 1'b0}, // R7
    '{4'd8, 32'h0010FFF0, 32'h0,        5'd3, 32'h0007FFF8, 1'b1}, // R8
    '{4'd8, 32'h0003FFFC, 32'h0,        5'd3, 32'h0003FFFC, 1'b0}, // R8
    '{4'd9, 32'h80000020, 32'h0,        5'd4, 32'h0000000F, 1'b1}, // R8
    '{4'd9, 32'h0005000A, 32'h0,        5'd4, 32'h0005000A, 1'b0}, // R8
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h80000000, 1'b1}, // R9
    '{4'd0, 32'hFFFFFFFF, 32'h00000001, 5'd0, 32'h00000000, 1'b0}, // R9
    '{4'd15, 32'h00000005, 32'h00000005, 5'd0, 32'h00000000, 1'b0} // R12
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  pos_i = '0;
  logic        clr_q_i = 1'b0;
  logic [31:0] res_o;
  logic        q_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  sat_arith_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .pos_i(pos_i), .clr_q_i(clr_q_i),
    .res_o(res_o), .q_o(q_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_q();
    @(negedge clk_i);
    valid_i = 1'b0; clr_q_i = 1'b1;
    @(negedge clk_i);
    clr_q_i = 1'b0;
  endtask

  initial begin
    #(CLK_P*100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R12 reset q", {31'b0, q_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      clear_q();
      op_i = VEC[i].op; a_i = VEC[i].a; b_i = VEC[i].b; pos_i = VEC[i].pos;
      valid_i = 1'b1;
      #1;
      chk($sformatf("vec%0d op%0d result", i, VEC[i].op), res_o, VEC[i].res);
      @(negedge clk_i);
      valid_i = 1'b0;
      chk($sformatf("vec%0d op%0d q", i, VEC[i].op), {31'b0, q_o}, {31'b0, VEC[i].q});
    end

    // R10: clamp with valid low leaves q at 0
    clear_q();
    op_i = 4'd3; a_i = 32'hFFFFFFFF; b_i = 32'h1; valid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 no valid", {31'b0, q_o}, 32'd0);

    // R10: set, then non-clamping valid op keeps q high
    valid_i = 1'b1;
    @(negedge clk_i);
    chk("R10 set", {31'b0, q_o}, 32'd1);
    a_i = 32'h1; b_i = 32'h1;
    @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R10 sticky", {31'b0, q_o}, 32'd1);

    // R11: clear together with a clamp -> q stays 1
    a_i = 32'hFFFFFFFF; valid_i = 1'b1; clr_q_i = 1'b1;
    @(negedge clk_i);
    chk("R11 set wins", {31'b0, q_o}, 32'd1);
    // R11: clear alone
    valid_i = 1'b0;
    @(negedge clk_i);
    clr_q_i = 1'b0;
    chk("R11 clear", {31'b0, q_o}, 32'd0);

    // R12: reset mid-run clears q
    op_i = 4'd4; a_i = 32'h0; b_i = 32'h1; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R4 q before reset", {31'b0, q_o}, 32'd1);
    rst_ni = 1'b0;
    #1;
    chk("R12 async reset", {31'b0, q_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule